// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block generates the pin-level timing of an 8-bit multiplexed external memory bus, one step per oscillator clock. A machine cycle is twelve oscillator periods split into two six-period halves. An address latch strobe pulses at the start of every half, and the low address byte travels on a shared 8-bit bus that later carries data. The high address byte sits on its own 8-bit port. Code reads use a dedicated active-low code strobe. Data reads and writes use their own active-low strobes, which span most of a machine cycle.

A requester asks for a code fetch or a data access. A request is taken only at the last period of a machine cycle, and the block acknowledges it in that period. A fetch fetches two consecutive code bytes, one per half. Each fetch slot whose address lies below a limit (8192 by default) stays on chip when the local-code enable is high, and then it produces no external activity. Read bytes are captured off the shared bus and presented with a one-cycle valid pulse.

Top module: `ext_bus_seq`

## Requirements
- R1: Phase 0 is the first period after the accepting edge. The address latch strobe `addr_latch` is high in steps 0 and 1 of each six-period half (phases 0-1 and 6-7) and low otherwise. It keeps running in idle and on-chip cycles, so consecutive rising edges are normally six periods apart.
- R2: In a data read or data write machine cycle, the second latch pulse (phases 6-7) is omitted, which leaves a twelve-period gap.
- R3: In an external fetch slot, the bus is driven with the low byte of the slot address in steps 0-2, one period past the latch fall. `code_rd_n` is low in steps 3-5 only, and the bus is released while it is low.
- R4: A fetch request (`req_data`=0) covers two slots. The first half uses `req_addr` and the second half uses `req_addr`+1, wrapping modulo 65536.
- R5: A fetch slot is kept on chip when `local_code_en`, sampled at acceptance, is 1 and the slot address is below 8192. Such a slot drives no bus, leaves `code_rd_n` high and captures nothing. Any other fetch slot is external.
- R6: A data read (`req_data`=1, `req_write`=0) drives its address on the bus in phases 0-2 and then releases the bus. `data_rd_n` is low in phases 5-10, six periods starting three periods after the latch fall.
- R7: A data write (`req_data`=1, `req_write`=1) drives the address in phases 0-2 and `req_wdata` in phases 3-11. `data_wr_n` is low in phases 5-10, so data leads the fall by two periods and holds one period past the rise.
- R8: During an external fetch slot or a data cycle, `addr_hi` carries bits 15:8 of the slot address.
- R9: The bus is sampled on the clock edge that ends the last low period of `code_rd_n` or `data_rd_n`. `rdata` holds that byte, and `rdata_valid` is high for exactly the following period.
- R10: A request is taken only in phase 11, where `req_ack` equals `req_valid`. A request shown in any other phase has no effect. Without a request, the next machine cycle is idle: no strobe, no bus drive.
- R11: While `rst` is high, the block sits in phase 11 idle. `addr_latch` is low, all strobes are high, the bus is released and `rdata_valid` is low.
- R12: At most one of `code_rd_n`, `data_rd_n`, `data_wr_n` is low at a time, and the bus is never driven while a read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_data | input | 1 | 0 = code fetch, 1 = data access |
| req_write | input | 1 | For data access: 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| local_code_en | input | 1 | Allows on-chip fetch below the limit |
| bus_in | input | 8 | Shared bus input value |
| req_ack | output | 1 | Request taken this period |
| addr_latch | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | Code read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |
| bus_oe | output | 1 | Shared bus drive enable |
| bus_out | output | 8 | Shared bus driven value |
| addr_hi | output | 8 | High address byte port |
| rdata | output | 8 | Last captured read byte |
| rdata_valid | output | 1 | One-period pulse for a new `rdata` |

## Verification
The bench targets fetch pairs that straddle the on-chip limit (8191 to 8192) and the wrap from 65535 to 0. A design that picked the on-chip decision once per request, or that carried the increment into bit 16, would show a code strobe in the wrong half or a wrong `addr_hi`. The bus changes value every period, so a capture one edge early or late returns a neighbouring byte. Requests are also offered mid-cycle and as one-period blips. An acceptance rule that is not pinned to phase 11 would shift every strobe or start a stray write. Data cycles check the missing second latch pulse and the write data window on both sides of the strobe.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
    localparam int SEQ_ADDR_W = 16;
    localparam int SEQ_DATA_W = 8;
    localparam int SEQ_HI_W   = SEQ_ADDR_W - SEQ_DATA_W;

    // Oscillator-period timing of one machine cycle
    localparam int HALF_LEN   = 6;
    localparam int MC_LEN     = 2 * HALF_LEN;
    localparam int PH_W       = $clog2(MC_LEN);
    localparam int STEP_W     = $clog2(HALF_LEN);
    localparam int LATCH_HIGH = 2;
    localparam int ADDR_HOLD  = 1;
    localparam int CODE_GAP   = 1;
    localparam int CODE_LEN   = 3;
    localparam int XS_GAP     = 3;
    localparam int XS_LEN     = 6;
    localparam int WD_LEAD    = 2;

    localparam int ADDR_END   = LATCH_HIGH + ADDR_HOLD;
    localparam int CODE_START = LATCH_HIGH + CODE_GAP;
    localparam int CODE_END   = CODE_START + CODE_LEN;
    localparam int XS_START   = LATCH_HIGH + XS_GAP;
    localparam int XS_END     = XS_START + XS_LEN;
    localparam int WD_START   = XS_START - WD_LEAD;

    typedef enum logic [1:0] {
        MC_IDLE,
        MC_FETCH,
        MC_DREAD,
        MC_DWRITE
    } mc_kind_e;

    typedef struct packed {
        mc_kind_e                kind;
        logic [SEQ_ADDR_W-1:0]   addr;
        logic [SEQ_DATA_W-1:0]   wdata;
        logic                    local_en;
    } mc_ctx_t;

    function automatic logic in_window(int pos, int lo, int hi);
        return (pos >= lo) && (pos < hi);
    endfunction

    function automatic mc_kind_e kind_of(logic is_data, logic is_write);
        if (!is_data)
            return MC_FETCH;
        return is_write ? MC_DWRITE : MC_DREAD;
    endfunction
endpackage

// File: rtl/bus_seq_phase.sv
module bus_seq_phase
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [PH_W-1:0]   phase,
    output logic [STEP_W-1:0] step,
    output logic              half,
    output logic              boundary
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(MC_LEN - 1);
    localparam logic [PH_W-1:0] HALF_PH = PH_W'(HALF_LEN);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= LAST_PH;
        else if (boundary)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_comb begin
        boundary = (phase == LAST_PH);
        half     = (phase >= HALF_PH);
        step     = half ? STEP_W'(phase - HALF_PH) : STEP_W'(phase);
    end
endmodule

// File: rtl/bus_seq_req.sv
module bus_seq_req
    import bus_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boundary,
    input  logic                  req_valid,
    input  logic                  req_data,
    input  logic                  req_write,
    input  logic [SEQ_ADDR_W-1:0] req_addr,
    input  logic [SEQ_DATA_W-1:0] req_wdata,
    input  logic                  local_code_en,
    output logic                  req_ack,
    output mc_ctx_t               ctx
);
    assign req_ack = req_valid && boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.kind     <= MC_IDLE;
            ctx.addr     <= '0;
            ctx.wdata    <= '0;
            ctx.local_en <= 1'b0;
        end else if (boundary) begin
            ctx.kind <= req_valid ? kind_of(req_data, req_write) : MC_IDLE;
            if (req_valid) begin
                ctx.addr     <= req_addr;
                ctx.wdata    <= req_wdata;
                ctx.local_en <= local_code_en;
            end
        end
    end
endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe
    import bus_seq_pkg::*;
#(
    parameter int INT_LIMIT = 8192
) (
    input  mc_ctx_t               ctx,
    input  logic [PH_W-1:0]       phase,
    input  logic [STEP_W-1:0]     step,
    input  logic                  half,
    output logic                  addr_latch,
    output logic                  code_rd_n,
    output logic                  data_rd_n,
    output logic                  data_wr_n,
    output logic                  bus_oe,
    output logic [SEQ_DATA_W-1:0] bus_out,
    output logic [SEQ_HI_W-1:0]   addr_hi,
    output logic                  cap_en
);
    localparam logic [SEQ_ADDR_W:0] LIMIT_V = (SEQ_ADDR_W + 1)'(INT_LIMIT);

    logic                  fetch_k, dread_k, dwrite_k, data_k;
    logic                  slot_local, ext_slot, wdata_win;
    logic [SEQ_ADDR_W-1:0] slot_addr;
    int                    ph_i, st_i;

    always_comb begin
        ph_i       = int'(phase);
        st_i       = int'(step);
        fetch_k    = (ctx.kind == MC_FETCH);
        dread_k    = (ctx.kind == MC_DREAD);
        dwrite_k   = (ctx.kind == MC_DWRITE);
        data_k     = dread_k || dwrite_k;

        // second half of a fetch addresses the next code byte
        slot_addr  = ctx.addr + SEQ_ADDR_W'(fetch_k && half);
        slot_local = ctx.local_en && ({1'b0, slot_addr} < LIMIT_V);
        ext_slot   = fetch_k && !slot_local;
        wdata_win  = dwrite_k && in_window(ph_i, WD_START, MC_LEN);

        addr_latch = in_window(st_i, 0, LATCH_HIGH) && !(data_k && half);
        code_rd_n  = !(ext_slot && in_window(st_i, CODE_START, CODE_END));
        data_rd_n  = !(dread_k && in_window(ph_i, XS_START, XS_END));
        data_wr_n  = !(dwrite_k && in_window(ph_i, XS_START, XS_END));

        bus_oe     = (ext_slot && in_window(st_i, 0, ADDR_END))
                   || (data_k && in_window(ph_i, 0, ADDR_END))
                   || wdata_win;
        bus_out    = wdata_win ? ctx.wdata : slot_addr[SEQ_DATA_W-1:0];
        addr_hi    = slot_addr[SEQ_ADDR_W-1:SEQ_DATA_W];

        cap_en     = (ext_slot && (st_i == CODE_END - 1))
                   || (dread_k && (ph_i == XS_END - 1));
    end
endmodule

// File: rtl/bus_seq_capture.sv
module bus_seq_capture
    import bus_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_en,
    input  logic [SEQ_DATA_W-1:0] bus_in,
    output logic [SEQ_DATA_W-1:0] rdata,
    output logic                  rdata_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= cap_en;
            if (cap_en)
                rdata <= bus_in;
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import bus_seq_pkg::*;
#(
    parameter int INT_LIMIT = 8192
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_data,
    input  logic                  req_write,
    input  logic [SEQ_ADDR_W-1:0] req_addr,
    input  logic [SEQ_DATA_W-1:0] req_wdata,
    input  logic                  local_code_en,
    input  logic [SEQ_DATA_W-1:0] bus_in,
    output logic                  req_ack,
    output logic                  addr_latch,
    output logic                  code_rd_n,
    output logic                  data_rd_n,
    output logic                  data_wr_n,
    output logic                  bus_oe,
    output logic [SEQ_DATA_W-1:0] bus_out,
    output logic [SEQ_HI_W-1:0]   addr_hi,
    output logic [SEQ_DATA_W-1:0] rdata,
    output logic                  rdata_valid
);
    logic [PH_W-1:0]   phase;
    logic [STEP_W-1:0] step;
    logic              half;
    logic              boundary;
    logic              cap_en;
    mc_ctx_t           ctx;

    bus_seq_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .step     (step),
        .half     (half),
        .boundary (boundary)
    );

    bus_seq_req u_req (
        .clk           (clk),
        .rst           (rst),
        .boundary      (boundary),
        .req_valid     (req_valid),
        .req_data      (req_data),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .local_code_en (local_code_en),
        .req_ack       (req_ack),
        .ctx           (ctx)
    );

    bus_seq_strobe #(.INT_LIMIT(INT_LIMIT)) u_strobe (
        .ctx        (ctx),
        .phase      (phase),
        .step       (step),
        .half       (half),
        .addr_latch (addr_latch),
        .code_rd_n  (code_rd_n),
        .data_rd_n  (data_rd_n),
        .data_wr_n  (data_wr_n),
        .bus_oe     (bus_oe),
        .bus_out    (bus_out),
        .addr_hi    (addr_hi),
        .cap_en     (cap_en)
    );

    bus_seq_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .cap_en      (cap_en),
        .bus_in      (bus_in),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       addr_latch,
    input logic       code_rd_n,
    input logic       data_rd_n,
    input logic       data_wr_n,
    input logic       bus_oe,
    input logic       req_ack,
    input logic       rdata_valid,
    input logic [7:0] addr_hi
);
    logic       latch_q;
    logic       seen;
    logic [3:0] gap;
    logic       latch_rise;

    assign latch_rise = addr_latch && !latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            seen    <= 1'b0;
            gap     <= '0;
        end else begin
            latch_q <= addr_latch;
            if (latch_rise) begin
                gap  <= 4'd1;
                seen <= 1'b1;
            end else if (gap != 4'hF) begin
                gap <= gap + 4'd1;
            end
        end
    end

    // R1, R2: rising edges are six apart, or twelve when a pulse is dropped
    a_r1_latch_period: assert property (@(posedge clk) disable iff (rst)
        (latch_rise && seen) |-> (gap == 4'd6 || gap == 4'd12));

    a_r1_latch_width: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_latch) |-> ($past(addr_latch) && $past(addr_latch, 2) && !$past(addr_latch, 3)));

    a_r1_no_strobe_in_latch: assert property (@(posedge clk) disable iff (rst)
        addr_latch |-> (code_rd_n && data_rd_n && data_wr_n));

    a_r3_code_lead: assert property (@(posedge clk) disable iff (rst)
        $fell(code_rd_n) |-> (!addr_latch && !$past(addr_latch) && $past(addr_latch, 2)));

    // R6 and R7: data strobes fall three periods after the latch fall
    a_r6_xs_lead: assert property (@(posedge clk) disable iff (rst)
        ($fell(data_rd_n) || $fell(data_wr_n)) |->
        (!addr_latch && !$past(addr_latch) && !$past(addr_latch, 2)
         && !$past(addr_latch, 3) && $past(addr_latch, 4)));

    a_r7_write_drives: assert property (@(posedge clk) disable iff (rst)
        !data_wr_n |-> bus_oe);

    a_r7_write_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(data_wr_n) |-> bus_oe);

    a_r8_hi_stable: assert property (@(posedge clk) disable iff (rst)
        (!code_rd_n || !data_rd_n || !data_wr_n) |-> $stable(addr_hi));

    a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> ($rose(code_rd_n) || $rose(data_rd_n)));

    a_r10_ack_starts_cycle: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> $rose(addr_latch));

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!code_rd_n, !data_rd_n, !data_wr_n}));

    a_r12_bus_free: assert property (@(posedge clk) disable iff (rst)
        (!code_rd_n || !data_rd_n) |-> !bus_oe);
endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_latch  (addr_latch),
    .code_rd_n   (code_rd_n),
    .data_rd_n   (data_rd_n),
    .data_wr_n   (data_wr_n),
    .bus_oe      (bus_oe),
    .req_ack     (req_ack),
    .rdata_valid (rdata_valid),
    .addr_hi     (addr_hi)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_data = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        local_code_en = 1'b0;
    logic [7:0]  bus_in = '0;
    logic        req_ack, addr_latch, code_rd_n, data_rd_n, data_wr_n, bus_oe;
    logic [7:0]  bus_out, addr_hi, rdata;
    logic        rdata_valid;

    ext_bus_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .local_code_en(local_code_en), .bus_in(bus_in), .req_ack(req_ack),
        .addr_latch(addr_latch), .code_rd_n(code_rd_n), .data_rd_n(data_rd_n),
        .data_wr_n(data_wr_n), .bus_oe(bus_oe), .bus_out(bus_out),
        .addr_hi(addr_hi), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rcnt = 0;

    // request script: delay before showing, kind, address, data, local enable
    localparam int NREQ = 12;
    int q_dly  [NREQ] = '{3, 0, 0, 5, 0, 0, 0, 20, 0, 0, 0, 0};
    int q_data [NREQ] = '{0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 1, 0};
    int q_wr   [NREQ] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0};
    int q_addr [NREQ] = '{'h2345, 'h0100, 'h1FFF, 'h8001, 'h4055, 'h12FE,
                          'h00FF, 'hFFFF, 'hFFFF, 'h9000, 'h7F80, 'h0042};
    int q_wd   [NREQ] = '{0, 0, 0, 0, 'hA5, 'h3C, 0, 0, 0, 0, 0, 0};
    int q_loc  [NREQ] = '{0, 1, 1, 0, 0, 0, 1, 0, 1, 1, 0, 0};
    int ri = 0;
    int dly = 0;
    int post = 0;
    bit blip_done = 1'b0;

    // reference model state
    int m_ph, m_kind, m_addr, m_wd;
    bit m_loc;
    bit exp_v = 1'b0;
    logic [7:0] exp_rd = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        dly = q_dly[0];
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog run did not end");
        finish_run();
    end

    always @(negedge clk) begin
        int h, s, sa;
        bit sloc, ext, dat, e_lat, e_code, e_rd, e_wr, e_oe, cap;
        int e_bus;
        cap = 1'b0;
        cyc++;
        if (rst) begin
            // R11: idle outputs during reset
            chk(!addr_latch && code_rd_n && data_rd_n && data_wr_n && !bus_oe && !rdata_valid,
                "R11", "reset outputs",
                {addr_latch, code_rd_n, data_rd_n, data_wr_n, bus_oe, rdata_valid}, 6'b011100);
            m_ph = 11; m_kind = 0; m_addr = 0; m_wd = 0; m_loc = 0; exp_v = 0;
            rcnt++;
            if (rcnt == 4) rst = 1'b0;
        end else begin
            h    = m_ph / 6;
            s    = m_ph % 6;
            sa   = (m_addr + ((m_kind == 1) ? h : 0)) % 65536;
            sloc = m_loc && (sa < 8192);
            ext  = (m_kind == 1) && !sloc;
            dat  = (m_kind >= 2);
            e_lat  = (s < 2) && !(dat && h == 1);
            e_code = !(ext && s >= 3);
            e_rd   = !(m_kind == 2 && m_ph >= 5 && m_ph <= 10);
            e_wr   = !(m_kind == 3 && m_ph >= 5 && m_ph <= 10);
            e_oe   = (ext && s <= 2) || (dat && m_ph <= 2) || (m_kind == 3);
            e_bus  = (m_kind == 3 && m_ph >= 3) ? m_wd : (sa % 256);

            chk(addr_latch == e_lat, dat ? "R2" : "R1", "addr_latch", addr_latch, e_lat);
            chk(code_rd_n == e_code, sloc ? "R5" : "R3", "code_rd_n", code_rd_n, e_code);
            chk(data_rd_n == e_rd, "R6", "data_rd_n", data_rd_n, e_rd);
            chk(data_wr_n == e_wr, "R7", "data_wr_n", data_wr_n, e_wr);
            chk(bus_oe == e_oe,
                (m_kind == 3) ? "R7" : (m_kind == 2) ? "R6" : sloc ? "R5" : (m_kind == 0) ? "R10" : "R3",
                "bus_oe", bus_oe, e_oe);
            if (e_oe)
                chk(bus_out == e_bus[7:0],
                    (m_kind == 1) ? "R4" : (m_kind == 3 && m_ph >= 3) ? "R7" : "R6",
                    "bus_out", bus_out, e_bus);
            if (ext || dat)
                chk(addr_hi == sa[15:8], "R8", "addr_hi", addr_hi, sa / 256);
            chk(rdata_valid == exp_v, "R9", "rdata_valid", rdata_valid, exp_v);
            if (exp_v)
                chk(rdata == exp_rd, "R9", "rdata", rdata, exp_rd);
            chk($countones({!code_rd_n, !data_rd_n, !data_wr_n}) <= 1, "R12", "strobe overlap",
                {code_rd_n, data_rd_n, data_wr_n}, 3'b111);
            cap = (ext && s == 5) || (m_kind == 2 && m_ph == 10);
        end

        if (!rst) begin
            bus_in = 8'(cyc * 37 + 11);
            exp_v  = cap;
            exp_rd = bus_in;

            // drive requests
            req_valid = 1'b0;
            if (ri < NREQ) begin
                if (dly > 0) begin
                    dly--;
                end else begin
                    req_valid     = 1'b1;
                    req_data      = q_data[ri][0];
                    req_write     = q_wr[ri][0];
                    req_addr      = q_addr[ri][15:0];
                    req_wdata     = q_wd[ri][7:0];
                    local_code_en = q_loc[ri][0];
                end
            end else begin
                post++;
                // R10: a one-period write request away from phase 11 must be ignored
                if (post >= 10 && m_ph == 3 && !blip_done) begin
                    req_valid = 1'b1; req_data = 1'b1; req_write = 1'b1;
                    req_addr = 16'h5A5A; req_wdata = 8'hEE;
                    blip_done = 1'b1;
                end
            end

            #1;
            chk(req_ack == (req_valid && m_ph == 11), "R10", "req_ack", req_ack,
                req_valid && m_ph == 11);

            // advance the model across the next edge
            if (m_ph == 11) begin
                m_ph = 0;
                if (req_valid) begin
                    m_kind = req_data ? (req_write ? 3 : 2) : 1;
                    m_addr = req_addr;
                    m_wd   = req_wdata;
                    m_loc  = local_code_en;
                    ri++;
                    if (ri < NREQ) dly = q_dly[ri];
                end else begin
                    m_kind = 0;
                end
            end else begin
                m_ph++;
            end

            if (post >= 60) finish_run();
        end
    end
endmodule